// File: doc/BRIEF.md
# Headphone Gain and Channel Control Target

This block is a write-only two-wire serial target that keeps a single 8-bit control word for a stereo headphone amplifier. A system clock oversamples the serial clock and data lines. The block finds bus start and stop conditions and checks the address byte. It pulls the data line low through an open-drain enable to acknowledge, and it accepts any number of data bytes in one transfer.

The stored word is decoded into registered amplifier controls: a signed gain in dB that follows a 32-step law from -76 dB to +18 dB, a mute flag, a left and a right channel enable, and a shutdown flag. A host changes volume or channel mode by writing one byte. The last byte written in a transfer wins.

Top module: `hp_vol_ctrl`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A start seen in the middle of a transfer begins a new address byte.
- R2: The address byte, read/write bit included, must equal 0xEC to be acknowledged. Any other value gets no acknowledge, and every byte up to the next start or stop is ignored.
- R3: Bits are taken on the rising clock edge, most significant bit first.
- R4: During the ninth clock after a matching address, and after every accepted data byte, the block drives the data line low (`sda_oe` = 1). At all other times it leaves the line released.
- R5: Each acknowledged data byte replaces the control word at the rising edge of its ninth clock. When several bytes arrive in one transfer, the last one is kept.
- R6: In the control word, bits 7:3 hold the volume code, bit 2 is mute, bit 1 is left enable and bit 0 is right enable. Codes 0 to 9 give -76, -62, -52, -44, -38, -34, -30, -27, -24 and -21 dB. Codes 10 to 25 give 2*code-38 dB. Codes 26 to 31 give code-13 dB.
- R7: While mute is set, the gain output is -76 dB whatever the volume code is.
- R8: The shutdown output is 1 exactly when both enable bits are 0.
- R9: A start or stop that arrives before the eighth bit of a byte throws the partial byte away, and the control word keeps its value.
- R10: After reset the control word is 0x00, gain is -76 dB, mute and both enables are 0, shutdown is 1 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| ctrl_word | output | 8 | Stored control word |
| gain_db | output | 8 | Effective gain in dB, two's complement |
| mute | output | 1 | Mute flag |
| left_en | output | 1 | Left channel enable |
| right_en | output | 1 | Right channel enable |
| shutdown | output | 1 | Both channels disabled |

## Verification
The mute override and the volume decode, together with the shutdown decode, can all change in the same cycle, because one data byte commits a new code, the mute bit and both enables at once. The bench provokes this with a byte that sets code 31 and mute and clears both enables. The gain must then read -76 dB rather than +18 dB, with shutdown high. A following byte that clears mute must bring back the code's own gain, so the override is known not to have stuck.

// File: rtl/hpvol_pkg.sv
package hpvol_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 5;
  localparam int GAIN_W = 8;
  localparam int MUTE_BIT  = 2;
  localparam int LEFT_BIT  = 1;
  localparam int RIGHT_BIT = 0;
  localparam logic signed [GAIN_W-1:0] GAIN_FLOOR = -8'sd76;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } tgt_state_e;

  // Non-uniform gain law: coarse steps at the bottom, 2 dB steps in the
  // middle band, 1 dB steps at the top.
  function automatic logic signed [GAIN_W-1:0] code_to_db(input logic [CODE_W-1:0] code);
    logic signed [GAIN_W-1:0] r;
    int c;
    c = int'(code);
    case (code)
      5'd0: r = -8'sd76;
      5'd1: r = -8'sd62;
      5'd2: r = -8'sd52;
      5'd3: r = -8'sd44;
      5'd4: r = -8'sd38;
      5'd5: r = -8'sd34;
      5'd6: r = -8'sd30;
      5'd7: r = -8'sd27;
      5'd8: r = -8'sd24;
      5'd9: r = -8'sd21;
      default: begin
        if (c < 26) r = GAIN_W'(2 * c - 38);
        else        r = GAIN_W'(c - 13);
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hpvol_sync.sv
module hpvol_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  // Idle bus is high on both lines, so the pipes reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

  // R1: start and stop are never flagged together
  assert_start_stop_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));

endmodule

// File: rtl/hpvol_target.sv
module hpvol_target
  import hpvol_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hEC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ctrl_q
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q;
  logic [BYTE_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic              sda_oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      shift_q  <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      ctrl_q   <= '0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            shift_q <= {shift_q[BYTE_W-2:0], sda_q};
            if (cnt_q == BIT_LAST) full_q <= 1'b1;
            else                   cnt_q  <= cnt_q + 1'b1;
          end else if (scl_fall && full_q) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            if (state_q == ST_DATA) begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_DATA_ACK;
            end else if (shift_q == DEV_ADDR) begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q  <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_DATA;
          end
        end
        ST_DATA_ACK: begin
          if (scl_rise) ctrl_q <= shift_q;
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

  // R4: the line is only grabbed while the clock is low
  assert_ack_on_low_clock_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_q) |-> !scl_q);

  // R2: a skipped transfer never acknowledges
  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SKIP) |-> !sda_oe_q);

  // R5: the control word only changes out of the data acknowledge phase
  assert_commit_in_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != $past(ctrl_q)) |-> ($past(state_q) == ST_DATA_ACK));

  // R1: a start always leads to address reception
  assert_start_to_addr_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state_q == ST_ADDR) && (cnt_q == '0));

endmodule

// File: rtl/hpvol_decode.sv
module hpvol_decode
  import hpvol_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [BYTE_W-1:0]        ctrl_q,
  output logic signed [GAIN_W-1:0] gain_q,
  output logic                     mute_q,
  output logic                     left_q,
  output logic                     right_q,
  output logic                     shut_q
);

  logic [CODE_W-1:0] code;
  assign code = ctrl_q[BYTE_W-1 -: CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q  <= GAIN_FLOOR;
      mute_q  <= 1'b0;
      left_q  <= 1'b0;
      right_q <= 1'b0;
      shut_q  <= 1'b1;
    end else begin
      gain_q  <= ctrl_q[MUTE_BIT] ? GAIN_FLOOR : code_to_db(code);
      mute_q  <= ctrl_q[MUTE_BIT];
      left_q  <= ctrl_q[LEFT_BIT];
      right_q <= ctrl_q[RIGHT_BIT];
      shut_q  <= ~(ctrl_q[LEFT_BIT] | ctrl_q[RIGHT_BIT]);
    end
  end

  // R7: muted output sits at the floor
  assert_mute_floor_R7: assert property (@(posedge clk) disable iff (rst)
    mute_q |-> (gain_q == GAIN_FLOOR));

  // R8: shutdown tracks both enables being clear
  assert_shutdown_R8: assert property (@(posedge clk) disable iff (rst)
    shut_q == (!left_q && !right_q));

  // R6: gain stays inside the law's range
  assert_gain_range_R6: assert property (@(posedge clk) disable iff (rst)
    (gain_q >= -8'sd76) && (gain_q <= 8'sd18));

endmodule

// File: rtl/hp_vol_ctrl.sv
module hp_vol_ctrl
  import hpvol_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] DEV_ADDR    = 8'hEC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  output logic [BYTE_W-1:0]        ctrl_word,
  output logic signed [GAIN_W-1:0] gain_db,
  output logic                     mute,
  output logic                     left_en,
  output logic                     right_en,
  output logic                     shutdown
);

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

  hpvol_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  hpvol_target #(.DEV_ADDR(DEV_ADDR)) tgt_i (
    .clk       (clk),
    .rst       (rst),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .ctrl_q    (ctrl_word)
  );

  hpvol_decode dec_i (
    .clk     (clk),
    .rst     (rst),
    .ctrl_q  (ctrl_word),
    .gain_q  (gain_db),
    .mute_q  (mute),
    .left_q  (left_en),
    .right_q (right_en),
    .shut_q  (shutdown)
  );

endmodule

// File: tb/hp_vol_ctrl_tb_top.sv
module hp_vol_ctrl_tb_top;

  localparam int Q = 20;           // system clocks per quarter serial bit
  localparam int NV = 8;
  localparam logic [7:0] MY_ADDR = 8'hEC;

  // stimulus: {address byte, data byte}
  localparam logic [15:0] VEC [NV] = '{
    16'hEC_9B, 16'hEC_FB, 16'hEC_07, 16'hED_55,
    16'hEC_D2, 16'h6C_FF, 16'hEC_01, 16'hEC_A0
  };

  localparam int GAIN_LAW [32] = '{
    -76, -62, -52, -44, -38, -34, -30, -27, -24, -21, -18, -16, -14, -12, -10, -8,
    -6, -4, -2, 0, 2, 4, 6, 8, 10, 12, 13, 14, 15, 16, 17, 18
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [7:0] ctrl_word;
  logic signed [7:0] gain_db;
  logic mute, left_en, right_en, shutdown;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_reg = 8'h00;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  hp_vol_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .ctrl_word (ctrl_word),
    .gain_db   (gain_db),
    .mute      (mute),
    .left_en   (left_en),
    .right_en  (right_en),
    .shutdown  (shutdown)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic get_ack(output logic a);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    a = ~sda_line;
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(a);
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic check_outputs(input string req);
    int g;
    g = exp_reg[2] ? -76 : GAIN_LAW[exp_reg[7:3]];
    chk({req, " ctrl_word"}, int'(ctrl_word), int'(exp_reg));
    chk({req, " gain_db"}, int'(gain_db), g);
    chk({req, " mute"}, int'(mute), int'(exp_reg[2]));
    chk({req, " left_en"}, int'(left_en), int'(exp_reg[1]));
    chk({req, " right_en"}, int'(right_en), int'(exp_reg[0]));
    chk({req, " shutdown"}, int'(shutdown), int'(exp_reg[1:0] == 2'b00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a0, a1, a2;
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    settle();

    // R10: reset state
    check_outputs("R10 reset");
    chk("R10 sda_oe", int'(sda_oe), 0);

    // vector walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [7:0] ad, dt;
      logic hit;
      ad = VEC[v][15:8];
      dt = VEC[v][7:0];
      hit = (ad == MY_ADDR);
      bus_start();
      put_byte(ad, a0);
      put_byte(dt, a1);
      bus_stop();
      settle();
      if (hit) exp_reg = dt;
      chk("R2 address ack", int'(a0), int'(hit));
      chk("R4 data ack", int'(a1), int'(hit));
      check_outputs("R6 vector");
    end

    // R5: several bytes in one transfer, last one kept
    bus_start();
    put_byte(MY_ADDR, a0);
    put_byte(8'h9B, a1);
    put_byte(8'h5F, a2);
    chk("R4 second byte ack", int'(a2), 1);
    put_byte(8'h3A, a2);
    bus_stop();
    settle();
    exp_reg = 8'h3A;
    chk("R5 third byte ack", int'(a2), 1);
    check_outputs("R5 last byte wins");

    // R7 R8: mute, volume and enables land together
    bus_start();
    put_byte(MY_ADDR, a0);
    put_byte(8'hFC, a1);
    bus_stop();
    settle();
    exp_reg = 8'hFC;
    chk("R7 muted gain", int'(gain_db), -76);
    chk("R8 shutdown on", int'(shutdown), 1);
    bus_start();
    put_byte(MY_ADDR, a0);
    put_byte(8'hF8, a1);
    bus_stop();
    settle();
    exp_reg = 8'hF8;
    chk("R7 unmuted gain", int'(gain_db), 18);
    check_outputs("R7 unmute");

    // R1: start in mid-byte restarts address reception
    bus_start();
    put_byte(MY_ADDR, a0);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    put_byte(MY_ADDR, a0);
    chk("R1 restart address ack", int'(a0), 1);
    put_byte(8'hD2, a1);
    bus_stop();
    settle();
    exp_reg = 8'hD2;
    check_outputs("R1 restart");

    // R9: stop in mid-byte drops the partial byte
    bus_start();
    put_byte(MY_ADDR, a0);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    settle();
    check_outputs("R9 partial dropped");

    // R3: bit order, code 1 with right enable only
    bus_start();
    put_byte(MY_ADDR, a0);
    put_byte(8'h09, a1);
    bus_stop();
    settle();
    exp_reg = 8'h09;
    chk("R3 msb first gain", int'(gain_db), -62);
    check_outputs("R3 bit order");

    // R10: reset after activity
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    settle();
    exp_reg = 8'h00;
    check_outputs("R10 re-reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule